// File: doc/BRIEF.md
# Color Format Mux with Cursor Overlay

This block is the last color-selection stage of a display pipeline. Each valid pixel gets one 24-bit RGB result. A color-mode field picks the source. The source can be grayscale generator data, palette lookup output, or pipeline data taken after the blink stage. In the two 16-bit packed modes, the pipeline word is unpacked and each channel is widened to 8 bits. The widening copies the channel's top bits into the empty low bits, so full-scale input gives full-scale output.

A hardware cursor overlay works on the formatted pixel. The overlay is active when either of two enable inputs is set and the pixel lies inside the cursor. The hit flag and a 2-bit per-pixel code come from the cursor shape logic outside this block. The code selects one of these actions:
- leave the pixel as it is
- replace it with cursor color 1
- replace it with cursor color 2
- invert all of its bits

The result is registered once, and the valid flag is aligned with the data.

Top module: `color_fmt_mux`

## Requirements
- R1: With `mode` = 0, the result is `lut_rgb`.
- R2: With `mode` = 1, the result is `gray_rgb`.
- R3: With `mode` = 2, and also for the unassigned codes 5, 6 and 7, the result is `pipe_rgb` unchanged (24 bpp).
- R4: With `mode` = 3 (565), the red, green and blue fields are `pipe_rgb[15:11]`, `[10:5]` and `[4:0]`. Each field is widened to 8 bits as (v<<3)|(v>>2) for 5-bit fields and (v<<2)|(v>>4) for the 6-bit field. Output order is R in `[23:16]`, G in `[15:8]` and B in `[7:0]`.
- R5: With `mode` = 4 (555), the fields are `pipe_rgb[14:10]`, `[9:5]` and `[4:0]`, each widened as (v<<3)|(v>>2). `pipe_rgb[15]` and `pipe_rgb[23:16]` have no effect.
- R6: The cursor is active only when (`cur_en_a` OR `cur_en_b`) AND `cur_hit`. If the cursor is inactive, or the code is 00 (transparent), the formatted pixel passes through.
- R7: When the cursor is active, code 01 gives `cur_color1` and code 10 gives `cur_color2`.
- R8: When the cursor is active, code 11 gives the bitwise inverse of all 24 bits of the formatted pixel.
- R9: A pixel presented with `in_valid` appears on `out_rgb` with `out_valid` = 1 one clock later. While `rst` is high, `out_valid` is 0 and `out_rgb` is 0.
- R10: After a clock with `in_valid` = 0, `out_valid` is 0 and `out_rgb` keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A pixel is presented this cycle |
| mode | input | 3 | Color-mode field |
| gray_rgb | input | 24 | Grayscale generator data |
| lut_rgb | input | 24 | Palette lookup output |
| pipe_rgb | input | 24 | Pipeline data after the blink stage |
| cur_en_a | input | 1 | Cursor enable, first control bit |
| cur_en_b | input | 1 | Cursor enable, second control bit |
| cur_hit | input | 1 | Pixel lies inside the cursor region |
| cur_code | input | 2 | Cursor pixel code |
| cur_color1 | input | 24 | Cursor color 1 |
| cur_color2 | input | 24 | Cursor color 2 |
| out_valid | output | 1 | Registered result is valid |
| out_rgb | output | 24 | Registered RGB result |

## Verification
The bench sweeps both packed modes over thousands of 16-bit words and compares the result with the arithmetic widening formula.
- A design with a misplaced field boundary or a zero-filled low part would show wrong low bits or swapped channels.
- A design that let bit 15 or the upper byte leak into the 555 result would fail on words with those bits set.

Every mode, including the unassigned codes, is crossed with every combination of the two enables, the hit flag and the four cursor codes. This catches an overlay that needs both enables, ignores the hit flag, or inverts the raw source instead of the formatted pixel. Idle cycles with changing inputs would expose a result register that loads without `in_valid`.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  // color-mode field codes
  localparam logic [2:0] MODE_LUT   = 3'd0;
  localparam logic [2:0] MODE_GRAY  = 3'd1;
  localparam logic [2:0] MODE_RGB24 = 3'd2;
  localparam logic [2:0] MODE_565   = 3'd3;
  localparam logic [2:0] MODE_555   = 3'd4;

  // cursor pixel codes
  typedef enum logic [1:0] {
    CUR_CLEAR  = 2'b00,
    CUR_COLOR1 = 2'b01,
    CUR_COLOR2 = 2'b10,
    CUR_INVERT = 2'b11
  } cur_code_e;

  // packed 16-bit field widths
  localparam int unsigned PK_R_W   = 5;
  localparam int unsigned PK_G6_W  = 6;
  localparam int unsigned PK_G5_W  = 5;
  localparam int unsigned PK_B_W   = 5;
  localparam int unsigned PK_WORD  = 16;
endpackage

// File: rtl/cfm_widen.sv
// Widens an IN_W-bit channel to OUT_W bits by repeating its MSBs downward.
module cfm_widen #(
  parameter int unsigned IN_W  = 5,
  parameter int unsigned OUT_W = 8
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (IN_W >= OUT_W) begin : g_trunc
      assign dout = din[IN_W-1 -: OUT_W];
    end else begin : g_rep
      for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        localparam int unsigned SRC = IN_W - 1 - ((OUT_W - 1 - i) % IN_W);
        assign dout[i] = din[SRC];
      end
    end
  endgenerate
endmodule

// File: rtl/cfm_unpack.sv
// Unpacks a 16-bit word in 565 and 555 layouts into full-width RGB.
module cfm_unpack
  import cfm_pkg::*;
#(
  parameter int unsigned CH_W = 8,
  localparam int unsigned PIX_W = 3 * CH_W
) (
  input  logic [PK_WORD-1:0] word,
  output logic [PIX_W-1:0]   rgb565,
  output logic [PIX_W-1:0]   rgb555
);
  localparam int unsigned G6_LO = PK_B_W;
  localparam int unsigned R6_LO = PK_B_W + PK_G6_W;
  localparam int unsigned G5_LO = PK_B_W;
  localparam int unsigned R5_LO = PK_B_W + PK_G5_W;

  logic [CH_W-1:0] r6, g6, b6, r5, g5, b5;

  cfm_widen #(.IN_W(PK_R_W),  .OUT_W(CH_W)) u_r6 (.din(word[R6_LO +: PK_R_W]),  .dout(r6));
  cfm_widen #(.IN_W(PK_G6_W), .OUT_W(CH_W)) u_g6 (.din(word[G6_LO +: PK_G6_W]), .dout(g6));
  cfm_widen #(.IN_W(PK_B_W),  .OUT_W(CH_W)) u_b6 (.din(word[0 +: PK_B_W]),      .dout(b6));

  cfm_widen #(.IN_W(PK_R_W),  .OUT_W(CH_W)) u_r5 (.din(word[R5_LO +: PK_R_W]),  .dout(r5));
  cfm_widen #(.IN_W(PK_G5_W), .OUT_W(CH_W)) u_g5 (.din(word[G5_LO +: PK_G5_W]), .dout(g5));
  cfm_widen #(.IN_W(PK_B_W),  .OUT_W(CH_W)) u_b5 (.din(word[0 +: PK_B_W]),      .dout(b5));

  assign rgb565 = {r6, g6, b6};
  assign rgb555 = {r5, g5, b5};
endmodule

// File: rtl/cfm_src_sel.sv
// Chooses the primary pixel source from the color-mode field.
module cfm_src_sel
  import cfm_pkg::*;
#(
  parameter int unsigned CH_W = 8,
  localparam int unsigned PIX_W = 3 * CH_W
) (
  input  logic [2:0]       mode,
  input  logic [PIX_W-1:0] gray_rgb,
  input  logic [PIX_W-1:0] lut_rgb,
  input  logic [PIX_W-1:0] pipe_rgb,
  input  logic [PIX_W-1:0] rgb565,
  input  logic [PIX_W-1:0] rgb555,
  output logic [PIX_W-1:0] pix
);
  always_comb begin
    unique case (mode)
      MODE_LUT:  pix = lut_rgb;
      MODE_GRAY: pix = gray_rgb;
      MODE_565:  pix = rgb565;
      MODE_555:  pix = rgb555;
      default:   pix = pipe_rgb;
    endcase
  end
endmodule

// File: rtl/cfm_cursor.sv
// Applies the cursor action to the formatted pixel.
module cfm_cursor
  import cfm_pkg::*;
#(
  parameter int unsigned CH_W = 8,
  localparam int unsigned PIX_W = 3 * CH_W
) (
  input  logic             en_a,
  input  logic             en_b,
  input  logic             hit,
  input  logic [1:0]       code,
  input  logic [PIX_W-1:0] color1,
  input  logic [PIX_W-1:0] color2,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] result
);
  logic      active;
  cur_code_e op;

  assign active = (en_a | en_b) & hit;
  assign op     = cur_code_e'(code);

  always_comb begin
    result = pix;
    if (active) begin
      unique case (op)
        CUR_COLOR1: result = color1;
        CUR_COLOR2: result = color2;
        CUR_INVERT: result = ~pix;
        default:    result = pix;
      endcase
    end
  end
endmodule

// File: rtl/color_fmt_mux.sv
module color_fmt_mux
  import cfm_pkg::*;
#(
  parameter int unsigned CH_W = 8,
  localparam int unsigned PIX_W = 3 * CH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       mode,
  input  logic [PIX_W-1:0] gray_rgb,
  input  logic [PIX_W-1:0] lut_rgb,
  input  logic [PIX_W-1:0] pipe_rgb,
  input  logic             cur_en_a,
  input  logic             cur_en_b,
  input  logic             cur_hit,
  input  logic [1:0]       cur_code,
  input  logic [PIX_W-1:0] cur_color1,
  input  logic [PIX_W-1:0] cur_color2,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_rgb
);
  logic [PIX_W-1:0] rgb565, rgb555, src_pix, final_pix;

  cfm_unpack #(.CH_W(CH_W)) u_unpack (
    .word   (pipe_rgb[PK_WORD-1:0]),
    .rgb565 (rgb565),
    .rgb555 (rgb555)
  );

  cfm_src_sel #(.CH_W(CH_W)) u_sel (
    .mode     (mode),
    .gray_rgb (gray_rgb),
    .lut_rgb  (lut_rgb),
    .pipe_rgb (pipe_rgb),
    .rgb565   (rgb565),
    .rgb555   (rgb555),
    .pix      (src_pix)
  );

  cfm_cursor #(.CH_W(CH_W)) u_cur (
    .en_a   (cur_en_a),
    .en_b   (cur_en_b),
    .hit    (cur_hit),
    .code   (cur_code),
    .color1 (cur_color1),
    .color2 (cur_color2),
    .pix    (src_pix),
    .result (final_pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_rgb <= final_pix;
    end
  end
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker
  import cfm_pkg::*;
#(
  parameter int unsigned CH_W = 8,
  localparam int unsigned PIX_W = 3 * CH_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [2:0]       mode,
  input logic [PIX_W-1:0] gray_rgb,
  input logic [PIX_W-1:0] lut_rgb,
  input logic [PIX_W-1:0] pipe_rgb,
  input logic             cur_en_a,
  input logic             cur_en_b,
  input logic             cur_hit,
  input logic [1:0]       cur_code,
  input logic [PIX_W-1:0] cur_color1,
  input logic [PIX_W-1:0] cur_color2,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_rgb
);
  logic cur_on;
  assign cur_on = (cur_en_a | cur_en_b) & cur_hit;

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_rgb));

  p_lut_src_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == MODE_LUT && !cur_on) |=> out_rgb == $past(lut_rgb));

  p_gray_src_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == MODE_GRAY && !cur_on) |=> out_rgb == $past(gray_rgb));

  p_rgb24_src_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == MODE_RGB24 && !cur_on) |=> out_rgb == $past(pipe_rgb));

  p_color1_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cur_on && cur_code == 2'b01) |=> out_rgb == $past(cur_color1));

  p_color2_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cur_on && cur_code == 2'b10) |=> out_rgb == $past(cur_color2));

  p_invert_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cur_on && cur_code == 2'b11 && mode == MODE_LUT)
      |=> out_rgb == ~$past(lut_rgb));
endmodule

bind color_fmt_mux cfm_checker #(.CH_W(CH_W)) u_chk (.*);

// File: tb/color_fmt_mux_tb.sv
module color_fmt_mux_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [23:0] gray_rgb = '0, lut_rgb = '0, pipe_rgb = '0;
  logic        cur_en_a = 1'b0, cur_en_b = 1'b0, cur_hit = 1'b0;
  logic [1:0]  cur_code = 2'b00;
  logic [23:0] cur_color1 = '0, cur_color2 = '0;
  logic        out_valid;
  logic [23:0] out_rgb;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  color_fmt_mux u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .gray_rgb(gray_rgb), .lut_rgb(lut_rgb), .pipe_rgb(pipe_rgb),
    .cur_en_a(cur_en_a), .cur_en_b(cur_en_b), .cur_hit(cur_hit),
    .cur_code(cur_code), .cur_color1(cur_color1), .cur_color2(cur_color2),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] w5(input logic [4:0] v);
    return 8'((int'(v) << 3) | (int'(v) >> 2));
  endfunction
  function automatic logic [7:0] w6(input logic [5:0] v);
    return 8'((int'(v) << 2) | (int'(v) >> 4));
  endfunction

  function automatic logic [23:0] model_src(input logic [2:0] m);
    int d;
    d = int'(pipe_rgb);
    case (m)
      3'd0: return lut_rgb;
      3'd1: return gray_rgb;
      3'd3: return {w5(5'((d >> 11) & 31)), w6(6'((d >> 5) & 63)), w5(5'(d & 31))};
      3'd4: return {w5(5'((d >> 10) & 31)), w5(5'((d >> 5) & 31)), w5(5'(d & 31))};
      default: return pipe_rgb;
    endcase
  endfunction

  function automatic logic [23:0] model_out();
    logic [23:0] p;
    p = model_src(mode);
    if ((cur_en_a || cur_en_b) && cur_hit) begin
      case (cur_code)
        2'b01: p = cur_color1;
        2'b10: p = cur_color2;
        2'b11: p = ~p;
        default: ;
      endcase
    end
    return p;
  endfunction

  // inputs are set at a negedge; result is sampled at the following negedge
  task automatic step_check(string req);
    logic [23:0] exp;
    exp = model_out();
    in_valid = 1'b1;
    @(negedge clk);
    check(req, {23'd0, out_valid}, 24'd1);
    check(req, out_rgb, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] held;
    // reset state (R9)
    repeat (3) @(negedge clk);
    check("R9 reset valid", {23'd0, out_valid}, 24'd0);
    check("R9 reset data", out_rgb, 24'd0);
    rst = 1'b0;
    @(negedge clk);

    lut_rgb = 24'h13579B; gray_rgb = 24'h808080; pipe_rgb = 24'hA5C3E1;
    cur_color1 = 24'hFF0000; cur_color2 = 24'h00FF00;

    // R1, R2, R3 sources with no cursor
    mode = 3'd0; step_check("R1 lut");
    mode = 3'd1; step_check("R2 gray");
    for (int m = 2; m < 8; m++) begin
      if (m == 3 || m == 4) continue;
      mode = 3'(m); pipe_rgb = 24'h3C5A00 ^ 24'(m * 24'h010F1);
      step_check("R3 rgb24");
    end

    // R4 565 sweep, upper byte randomized-ish
    mode = 3'd3;
    for (int v = 0; v < 65536; v += 7) begin
      pipe_rgb = {8'(v * 37), 16'(v)};
      step_check("R4 565");
    end
    pipe_rgb = 24'h00FFFF; step_check("R4 565 full");
    pipe_rgb = 24'hFF0000; step_check("R4 565 zero");

    // R5 555 sweep, bit 15 and upper byte toggled
    mode = 3'd4;
    for (int v = 0; v < 65536; v += 7) begin
      pipe_rgb = {8'(v * 91), 16'(v)};
      step_check("R5 555");
    end
    pipe_rgb = 24'hFF7FFF; step_check("R5 555 full");
    pipe_rgb = 24'hFF8000; step_check("R5 555 bit15");

    // R6 R7 R8 cursor cross with every mode
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 4; e++) begin
        for (int h = 0; h < 2; h++) begin
          for (int c = 0; c < 4; c++) begin
            mode = 3'(m);
            cur_en_a = e[0]; cur_en_b = e[1]; cur_hit = h[0];
            cur_code = 2'(c);
            lut_rgb = 24'h102030 + 24'(m * 97 + c);
            gray_rgb = 24'h7F7F7F ^ 24'(e * 3 + h);
            pipe_rgb = 24'h9ABCDE ^ 24'(c * 4097 + m);
            if (c == 0 || e == 0 || h == 0) step_check("R6 transparent/inactive");
            else if (c == 3) step_check("R8 invert");
            else step_check("R7 cursor color");
          end
        end
      end
    end

    // R10 idle cycles hold data and drop valid
    cur_en_a = 1'b1; cur_hit = 1'b1; cur_code = 2'b01; mode = 3'd0;
    step_check("R7 before idle");
    held = out_rgb;
    for (int k = 0; k < 6; k++) begin
      in_valid = 1'b0;
      cur_color1 = 24'h0F0F0F + 24'(k); lut_rgb = 24'(k * 12345);
      mode = 3'(k);
      @(negedge clk);
      check("R10 idle valid", {23'd0, out_valid}, 24'd0);
      check("R10 idle hold", out_rgb, held);
    end
    step_check("R9 resume");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule